// File: doc/BRIEF.md
# Region-Based Memory Protection Unit

This block checks every instruction fetch and data access against up to eight programmable address windows. Each window carries an enable bit, a power-of-two size and a base aligned to that size. For each request the unit selects the highest-numbered enabled window that contains the address. It then returns that window's index, its permission nibble, and its cacheable and bufferable flags. It also flags a fault when no window matches or when the nibble does not grant the requested kind of access.

Software programs the unit through a single-cycle write port. Indices 0 to 7 hold the window registers. Index 8 is the global control word, 9 the data permission word, 10 the instruction permission word, 11 the data cacheable mask, 12 the instruction cacheable mask and 13 the bufferable mask. Lookups go through a separate request port, and the answer is registered one cycle later. Caches, write buffers and the exception logic that acts on the fault output are built elsewhere.

Top module: `region_guard`

## Requirements
- R1: A window register uses bit 0 as enable and bits [5:1] as size code N. The window covers 2^(max(N,5)+1) bytes. Its base is the register with every bit at or below max(N,5) treated as zero, so only the address bits above that position are compared.
- R2: When several enabled windows contain the address, the highest-numbered one is reported on rsp_region and supplies all attributes.
- R3: The permission nibble of window i occupies bits [4i+3:4i] of a permission word. Data accesses use word 9 and instruction fetches use word 10. Nibble bit 0 grants read and bit 1 grants write. An instruction fetch needs only bit 0, and req_write is disregarded for it.
- R4: With the global enable set, an access faults when no enabled window matches, or when the selected nibble lacks the needed grant. On a miss rsp_hit, rsp_region, rsp_perm, rsp_cacheable and rsp_bufferable are all 0.
- R5: rsp_cacheable is bit i of the data cacheable mask (index 11) for data accesses and of the instruction cacheable mask (index 12) for fetches, where i is the selected window.
- R6: rsp_bufferable is bit i of the bufferable mask (index 13) for data accesses and is 0 for instruction fetches.
- R7: Checking is active only while bit 0 of the control word (index 8) is 1. While it is 0, every response has rsp_hit, rsp_fault and all attributes at 0.
- R8: The response to a request presented in one cycle appears in the next cycle with rsp_valid set. rsp_valid is low in a cycle after no request. A register write is used by a lookup presented in the following cycle.
- R9: Synchronous reset clears every register, leaving checking disabled, and drives rsp_valid low.
- R10: Writes to indices 14 and 15 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | 32 | Access address |
| req_instr | input | 1 | 1 for instruction fetch, 0 for data |
| req_write | input | 1 | 1 for data write |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | A window matched |
| rsp_region | output | 3 | Selected window index |
| rsp_perm | output | 4 | Selected permission nibble |
| rsp_cacheable | output | 1 | Cacheable attribute |
| rsp_bufferable | output | 1 | Bufferable attribute |
| rsp_fault | output | 1 | Access denied |

## Verification
The assertions assume that a lookup and a register write never need an ordering within one cycle. A lookup issued together with a write sees the old contents. The stimulus therefore always places a full idle cycle between a write and the next request. The assertions also assume req_instr and req_write are stable while req_valid is high. The bench drives both only in the cycle it raises req_valid. Window layouts in the stimulus include overlapping, nested, disabled and full-address-space windows, so the priority checks see real contention.

// File: rtl/rgd_pkg.sv
package rgd_pkg;
  localparam logic [3:0] SEL_CTRL   = 4'd8;
  localparam logic [3:0] SEL_PERM_D = 4'd9;
  localparam logic [3:0] SEL_PERM_I = 4'd10;
  localparam logic [3:0] SEL_CACH_D = 4'd11;
  localparam logic [3:0] SEL_CACH_I = 4'd12;
  localparam logic [3:0] SEL_BUFM   = 4'd13;
  localparam int         MIN_SHIFT  = 5;
  localparam int         PERM_W     = 4;
endpackage

// File: rtl/rg_regs.sv
module rg_regs import rgd_pkg::*; #(
  parameter int NREG = 8,
  parameter int AW   = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [3:0]                 cfg_addr,
  input  logic [AW-1:0]              cfg_wdata,
  output logic [NREG-1:0][AW-1:0]    win_q,
  output logic                       glob_en,
  output logic [NREG*PERM_W-1:0]     perm_d,
  output logic [NREG*PERM_W-1:0]     perm_i,
  output logic [NREG-1:0]            cach_d,
  output logic [NREG-1:0]            cach_i,
  output logic [NREG-1:0]            bufm
);
  localparam int IW = $clog2(NREG);
  localparam int PWW = NREG * PERM_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q   <= '0;
      glob_en <= 1'b0;
      perm_d  <= '0;
      perm_i  <= '0;
      cach_d  <= '0;
      cach_i  <= '0;
      bufm    <= '0;
    end else if (cfg_we) begin
      if (cfg_addr < 4'(NREG)) begin
        win_q[cfg_addr[IW-1:0]] <= cfg_wdata;
      end else begin
        case (cfg_addr)
          SEL_CTRL:   glob_en <= cfg_wdata[0];
          SEL_PERM_D: perm_d  <= cfg_wdata[PWW-1:0];
          SEL_PERM_I: perm_i  <= cfg_wdata[PWW-1:0];
          SEL_CACH_D: cach_d  <= cfg_wdata[NREG-1:0];
          SEL_CACH_I: cach_i  <= cfg_wdata[NREG-1:0];
          SEL_BUFM:   bufm    <= cfg_wdata[NREG-1:0];
          default:    ;
        endcase
      end
    end
  end

  // R7
  ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == SEL_CTRL) |=> (glob_en == $past(cfg_wdata[0])));
endmodule

// File: rtl/rg_match.sv
module rg_match import rgd_pkg::*; #(
  parameter int NREG = 8,
  parameter int AW   = 32
) (
  input  logic [NREG-1:0][AW-1:0] win_q,
  input  logic [AW-1:0]           addr,
  output logic [NREG-1:0]         hit_vec
);
  for (genvar g = 0; g < NREG; g++) begin : g_win
    logic [4:0]    code;
    logic [AW-1:0] keep;
    always_comb begin
      code = win_q[g][5:1];
      for (int b = 0; b < AW; b++)
        keep[b] = (b > int'(code)) && (b > MIN_SHIFT);
      hit_vec[g] = win_q[g][0] && (((addr ^ win_q[g]) & keep) == '0);
    end
  end
endmodule

// File: rtl/rg_pick.sv
module rg_pick import rgd_pkg::*; #(
  parameter int NREG = 8
) (
  input  logic [NREG-1:0]          hit_vec,
  input  logic                     glob_en,
  input  logic                     is_instr,
  input  logic                     is_write,
  input  logic [NREG*PERM_W-1:0]   perm_d,
  input  logic [NREG*PERM_W-1:0]   perm_i,
  input  logic [NREG-1:0]          cach_d,
  input  logic [NREG-1:0]          cach_i,
  input  logic [NREG-1:0]          bufm,
  output logic                     o_hit,
  output logic [$clog2(NREG)-1:0]  o_idx,
  output logic [PERM_W-1:0]        o_perm,
  output logic                     o_cach,
  output logic                     o_buf,
  output logic                     o_fault
);
  localparam int IW = $clog2(NREG);
  logic          any;
  logic [IW-1:0] top;
  logic [PERM_W-1:0] nib;
  logic          granted;

  always_comb begin
    any = 1'b0;
    top = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit_vec[i]) begin
        any = 1'b1;
        top = IW'(i);
      end
    end
    nib     = is_instr ? perm_i[top*PERM_W +: PERM_W] : perm_d[top*PERM_W +: PERM_W];
    granted = (is_write && !is_instr) ? nib[1] : nib[0];
    o_hit   = glob_en && any;
    o_idx   = o_hit ? top : '0;
    o_perm  = o_hit ? nib : '0;
    o_cach  = o_hit && (is_instr ? cach_i[top] : cach_d[top]);
    o_buf   = o_hit && !is_instr && bufm[top];
    o_fault = glob_en && (!any || !granted);
  end
endmodule

// File: rtl/region_guard.sv
module region_guard import rgd_pkg::*; #(
  parameter int NREG = 8,
  parameter int AW   = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [3:0]               cfg_addr,
  input  logic [AW-1:0]            cfg_wdata,
  input  logic                     req_valid,
  input  logic [AW-1:0]            req_addr,
  input  logic                     req_instr,
  input  logic                     req_write,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic [$clog2(NREG)-1:0]  rsp_region,
  output logic [PERM_W-1:0]        rsp_perm,
  output logic                     rsp_cacheable,
  output logic                     rsp_bufferable,
  output logic                     rsp_fault
);
  localparam int IW = $clog2(NREG);

  logic [NREG-1:0][AW-1:0]   win_q;
  logic                      glob_en;
  logic [NREG*PERM_W-1:0]    perm_d, perm_i;
  logic [NREG-1:0]           cach_d, cach_i, bufm, hit_vec;
  logic                      c_hit, c_cach, c_buf, c_fault;
  logic [IW-1:0]             c_idx;
  logic [PERM_W-1:0]         c_perm;

  rg_regs #(.NREG(NREG), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .win_q(win_q), .glob_en(glob_en),
    .perm_d(perm_d), .perm_i(perm_i), .cach_d(cach_d),
    .cach_i(cach_i), .bufm(bufm));

  rg_match #(.NREG(NREG), .AW(AW)) u_match (
    .win_q(win_q), .addr(req_addr), .hit_vec(hit_vec));

  rg_pick #(.NREG(NREG)) u_pick (
    .hit_vec(hit_vec), .glob_en(glob_en), .is_instr(req_instr),
    .is_write(req_write), .perm_d(perm_d), .perm_i(perm_i),
    .cach_d(cach_d), .cach_i(cach_i), .bufm(bufm),
    .o_hit(c_hit), .o_idx(c_idx), .o_perm(c_perm),
    .o_cach(c_cach), .o_buf(c_buf), .o_fault(c_fault));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_region     <= '0;
      rsp_perm       <= '0;
      rsp_cacheable  <= 1'b0;
      rsp_bufferable <= 1'b0;
      rsp_fault      <= 1'b0;
    end else begin
      rsp_valid      <= req_valid;
      rsp_hit        <= req_valid && c_hit;
      rsp_region     <= req_valid ? c_idx : '0;
      rsp_perm       <= req_valid ? c_perm : '0;
      rsp_cacheable  <= req_valid && c_cach;
      rsp_bufferable <= req_valid && c_buf;
      rsp_fault      <= req_valid && c_fault;
    end
  end

  // R8
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R8
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R7
  disabled_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !glob_en) |=> (!rsp_fault && !rsp_hit && !rsp_cacheable && !rsp_bufferable));
  // R4
  miss_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && glob_en && hit_vec == '0) |=> (rsp_fault && !rsp_hit && rsp_perm == '0));
  // R2
  top_window_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && glob_en && hit_vec[NREG-1]) |=> (rsp_hit && rsp_region == IW'(NREG-1)));
  // R6
  fetch_nobuf_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_instr) |=> !rsp_bufferable);
endmodule

// File: tb/region_guard_test.sv
module region_guard_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        req_valid, req_instr, req_write;
  logic [31:0] req_addr;
  logic        rsp_valid, rsp_hit, rsp_cacheable, rsp_bufferable, rsp_fault;
  logic [2:0]  rsp_region;
  logic [3:0]  rsp_perm;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef logic [9:0] exp_t; // {hit, region[2:0], perm[3:0], cache, buf}
  typedef struct { exp_t v; logic f; string tag; } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  region_guard uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .req_instr(req_instr), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_region(rsp_region), .rsp_perm(rsp_perm),
    .rsp_cacheable(rsp_cacheable), .rsp_bufferable(rsp_bufferable),
    .rsp_fault(rsp_fault));

  task automatic cfg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(input logic [31:0] a, input logic ins, input logic wr,
                      input logic h, input logic [2:0] r, input logic [3:0] p,
                      input logic c, input logic b, input logic f, input string tag);
    item_t it;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_instr = ins; req_write = wr;
    it.v = {h, r, p, c, b}; it.f = f; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      item_t it;
      exp_t act;
      act = {rsp_hit, rsp_region, rsp_perm, rsp_cacheable, rsp_bufferable};
      n_chk++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R8: response with no request, actual %h expected none", act);
      end else begin
        it = sb.pop_front();
        if (act !== it.v || rsp_fault !== it.f) begin
          n_bad++;
          $display("FAIL %s: actual attr=%h fault=%b expected attr=%h fault=%b",
                   it.tag, act, rsp_fault, it.v, it.f);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; req_instr = 1'b0; req_write = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0) begin
      n_bad++;
      $display("FAIL R9: actual valid=%b fault=%b expected 0 0", rsp_valid, rsp_fault);
    end
    // reset leaves checking off: R9, R7
    look(32'h1234_5678, 0, 1, 0, 0, 0, 0, 0, 0, "R9 disabled after reset");
    idle();

    cfg(4'd0, 32'h0000_003D);
    cfg(4'd1, 32'hC000_002F);
    cfg(4'd2, 32'h0000_0031);
    cfg(4'd3, 32'h1000_0031);
    cfg(4'd4, 32'h4000_0017);
    cfg(4'd5, 32'hFF80_002D);
    cfg(4'd9,  32'h0333_3330);
    cfg(4'd10, 32'h0033_3310);
    cfg(4'd11, 32'h0000_0034);
    cfg(4'd12, 32'h0000_0024);
    cfg(4'd13, 32'h0000_0034);
    cfg(4'd8,  32'h0000_0001);

    look(32'h0000_1000, 0, 0, 1, 2, 3, 1, 1, 0, "R2 window 2 over 0");
    look(32'h1000_1000, 0, 1, 1, 3, 3, 0, 0, 0, "R2 window 3 over 0");
    look(32'h4000_0800, 0, 0, 1, 4, 3, 1, 1, 0, "R1 4KB window inside");
    look(32'h4000_1000, 0, 0, 1, 0, 0, 0, 0, 1, "R1 4KB window edge, R4 denied");
    look(32'hC0FF_FFFC, 0, 1, 1, 1, 3, 0, 0, 0, "R1 16MB window top");
    look(32'hC100_0000, 0, 0, 0, 0, 0, 0, 0, 1, "R4 miss");
    look(32'hFF80_0000, 1, 0, 1, 5, 3, 1, 0, 0, "R5 R6 fetch attrs");
    look(32'hC000_0000, 1, 1, 1, 1, 1, 0, 0, 0, "R3 fetch ignores write");
    look(32'hFF80_0000, 0, 0, 1, 5, 3, 1, 1, 0, "R5 R6 data attrs");
    look(32'h1000_0000, 1, 0, 1, 3, 3, 0, 0, 0, "R3 fetch perm word");
    idle();

    cfg(4'd6, 32'h2000_0A19);
    cfg(4'd9, 32'h0333_2330);
    look(32'h2000_1FFC, 0, 0, 1, 6, 3, 0, 0, 0, "R1 low bits ignored");
    look(32'h2000_2000, 0, 0, 1, 0, 0, 0, 0, 1, "R1 8KB window end");
    look(32'h1000_0000, 0, 0, 1, 3, 2, 0, 0, 1, "R3 write-only read");
    look(32'h1000_0004, 0, 1, 1, 3, 2, 0, 0, 0, "R3 write-only write");
    idle();

    cfg(4'd2, 32'h0000_0030);
    look(32'h0000_1000, 0, 0, 1, 0, 0, 0, 0, 1, "R1 disabled window, R8 new value");
    idle();

    cfg(4'd7, 32'h0000_003F);
    cfg(4'd9, 32'h1333_2330);
    look(32'hC100_0000, 0, 0, 1, 7, 1, 0, 0, 0, "R2 full-space window");
    look(32'hC000_0000, 0, 1, 1, 7, 1, 0, 0, 1, "R2 R3 top window wins, write denied");
    idle();

    cfg(4'd15, 32'h0000_0000);
    cfg(4'd14, 32'h0000_0000);
    look(32'hC100_0000, 0, 0, 1, 7, 1, 0, 0, 0, "R10 spare index no effect");
    idle();

    cfg(4'd8, 32'h0000_0000);
    look(32'hC100_0000, 0, 1, 0, 0, 0, 0, 0, 0, "R7 global disable");
    idle();

    repeat (3) @(negedge clk);
    n_chk++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R8: actual %0d pending expected 0", sb.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule